// File: doc/BRIEF.md
# Stream Buffer Valid-Bit Update

This block decides, for one communication stream, what happens to the stream's buffer register and its valid flag each time the stream runs a move instruction. Every executed move copies the moved word into the stream's own buffer. Whether that stored word is marked valid, and so resent when the stream is next scheduled, depends on three things: the opcode, the destination code, and whether the destination took the word.

There are three move flavours. A plain move ignores flow control. A chained move repeats the valid outcome of the stream that executed just before it. A flow-controlled move keeps a word that the destination refused. Neighbour ports report acceptance in the current cycle. The processor interface and the other buffer report a readiness status that was registered one cycle earlier. A write to the node memory space always succeeds. The outcome of each executed move is registered as a chain flag, which the following stream uses.

Top module: `stream_valid_update`

## Requirements
- R1: When `exec_i` is high and `op_i` is 0, 1 or 2, `buf_we_o` is high and `buf_data_o` equals `word_i` in that cycle. `buf_q_o` holds that word after the next rising edge.
- R2: A plain move (`op_i`=0) whose destination is 0 to 5 gives `next_valid_o`=0.
- R3: Any move (`op_i` 0, 1 or 2) whose destination is 7 (the stream's own buffer) gives `next_valid_o`=1.
- R4: A chained move (`op_i`=1) whose destination is 0 to 5 gives `next_valid_o` equal to `prev_valid_i`.
- R5: A flow-controlled move (`op_i`=2) to a port (destination 0 to 3) gives `next_valid_o` = NOT `port_accept_i[dest]`.
- R6: A flow-controlled move gives `next_valid_o` = NOT `proc_ready_i` when the destination is 4 (processor interface), and NOT `peer_ready_i` when the destination is 5 (other buffer).
- R7: Any move whose destination is 6 (memory space) gives `next_valid_o`=0.
- R8: After each executed move, `valid_q_o` and `chain_o` equal the `next_valid_o` of that move. They keep their values in every cycle without an executed move.
- R9: When `exec_i` is low, or `op_i` is 3 (reserved), `buf_we_o` is 0 and `buf_q_o`, `valid_q_o` and `chain_o` do not change.
- R10: A clock edge with `rst_n` low clears `valid_q_o`, `chain_o` and `buf_q_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-up reset, active low |
| exec_i | input | 1 | The stream executes an instruction this cycle |
| op_i | input | 2 | 0 plain, 1 chained, 2 flow-controlled, 3 reserved |
| dest_i | input | 3 | 0-3 port, 4 processor, 5 other buffer, 6 memory, 7 own buffer |
| word_i | input | DATA_W | Word being moved |
| port_accept_i | input | 4 | Accept bit from each neighbour port |
| proc_ready_i | input | 1 | Processor interface readiness, registered the cycle before |
| peer_ready_i | input | 1 | Other buffer readiness, registered the cycle before |
| prev_valid_i | input | 1 | Valid outcome of the previously executed stream |
| buf_we_o | output | 1 | Buffer write enable |
| buf_data_o | output | DATA_W | Data written into the buffer |
| next_valid_o | output | 1 | Valid bit that the buffer is about to take |
| buf_q_o | output | DATA_W | Buffer register contents |
| valid_q_o | output | 1 | Buffer valid bit |
| chain_o | output | 1 | Registered outcome for the following stream |

## Verification
A wrong valid decision shows up at once on `next_valid_o`, in the same cycle as the move. It also shows up on `valid_q_o` and `chain_o` one edge later. A missed or stray update of the state makes `buf_q_o` or `chain_o` differ from the last executed move by the next edge. That error persists until the next executed move, so it can be seen through idle and reserved-opcode cycles.

// File: rtl/stream_valid_update.sv
module stream_valid_update #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        dest_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [3:0]        port_accept_i,
  input  logic              proc_ready_i,
  input  logic              peer_ready_i,
  input  logic              prev_valid_i,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              next_valid_o,
  output logic [DATA_W-1:0] buf_q_o,
  output logic              valid_q_o,
  output logic              chain_o
);
  localparam logic [1:0] OP_PLAIN = 2'd0;
  localparam logic [1:0] OP_CHAIN = 2'd1;
  localparam logic [1:0] OP_FLOW  = 2'd2;
  localparam logic [2:0] D_MEM    = 3'd6;
  localparam logic [2:0] D_OWN    = 3'd7;

  logic flow_refused;
  logic move;

  assign move       = exec_i && (op_i != 2'd3);
  assign buf_we_o   = move;
  assign buf_data_o = word_i;

  assign flow_refused = dest_i[2] ? (dest_i[0] ? !peer_ready_i : !proc_ready_i)
                                  : !port_accept_i[dest_i[1:0]];

  always_comb begin
    if (dest_i == D_MEM)      next_valid_o = 1'b0;
    else if (dest_i == D_OWN) next_valid_o = 1'b1;
    else begin
      case (op_i)
        OP_CHAIN: next_valid_o = prev_valid_i;
        OP_FLOW:  next_valid_o = flow_refused;
        default:  next_valid_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q_o   <= '0;
      valid_q_o <= 1'b0;
      chain_o   <= 1'b0;
    end else if (move) begin
      buf_q_o   <= word_i;
      valid_q_o <= next_valid_o;
      chain_o   <= next_valid_o;
    end
  end

  assert_mem_always_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i != 2'd3 && dest_i == D_MEM) |=> !valid_q_o);

  assert_plain_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_PLAIN && dest_i < D_MEM) |=> !valid_q_o);

  assert_port_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_FLOW && !dest_i[2] && port_accept_i[dest_i[1:0]]) |=> !valid_q_o);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_i && op_i != 2'd3) |=> ($stable(valid_q_o) && $stable(chain_o) && $stable(buf_q_o)));

  assert_chain_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i != 2'd3) |=> (chain_o == valid_q_o && buf_q_o == $past(word_i)));

  assert_own_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i != 2'd3 && dest_i == D_OWN) |=> valid_q_o);
endmodule

// File: tb/stream_valid_update_tb.sv
module stream_valid_update_tb;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n, exec_i, proc_ready_i, peer_ready_i, prev_valid_i;
  logic [1:0] op_i;
  logic [2:0] dest_i;
  logic [W-1:0] word_i;
  logic [3:0] port_accept_i;
  logic buf_we_o, next_valid_o, valid_q_o, chain_o;
  logic [W-1:0] buf_data_o, buf_q_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  stream_valid_update #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .dest_i(dest_i),
    .word_i(word_i), .port_accept_i(port_accept_i), .proc_ready_i(proc_ready_i),
    .peer_ready_i(peer_ready_i), .prev_valid_i(prev_valid_i), .buf_we_o(buf_we_o),
    .buf_data_o(buf_data_o), .next_valid_o(next_valid_o), .buf_q_o(buf_q_o),
    .valid_q_o(valid_q_o), .chain_o(chain_o));

  // fields: [12:11] op, [10:8] dest, [7:4] accept, [3] proc, [2] peer, [1] prev, [0] expected valid
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 3'd0, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd0, 3'd7, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd0, 3'd5, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd1, 3'd2, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd1, 3'd4, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 3'd7, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd1, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd3, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd0, 4'b1110, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd4, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd4, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd5, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd2, 3'd5, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd2, 3'd6, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd1, 3'd6, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd7, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string rule(input logic [1:0] op, input logic [2:0] d);
    if (d == 3'd6) return "R7";
    if (d == 3'd7) return "R3";
    if (op == 2'd0) return "R2";
    if (op == 2'd1) return "R4";
    if (d < 3'd4) return "R5";
    return "R6";
  endfunction

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_i = 1'b0; op_i = '0; dest_i = '0; word_i = '0;
    port_accept_i = '0; proc_ready_i = 1'b0; peer_ready_i = 1'b0; prev_valid_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset valid", W'(valid_q_o), 0);
    chk("R10 reset chain", W'(chain_o), 0);
    chk("R10 reset buffer", buf_q_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      string t;
      v = VEC[i];
      t = rule(v[12:11], v[10:8]);
      @(negedge clk);
      exec_i = 1'b1; op_i = v[12:11]; dest_i = v[10:8]; port_accept_i = v[7:4];
      proc_ready_i = v[3]; peer_ready_i = v[2]; prev_valid_i = v[1];
      word_i = W'(32'h1000_0000 + i * 32'h0101);
      #1;
      chk($sformatf("%s vec %0d next_valid", t, i), W'(next_valid_o), W'(v[0]));
      chk($sformatf("R1 vec %0d we", i), W'(buf_we_o), 1);
      chk($sformatf("R1 vec %0d data", i), buf_data_o, word_i);
      @(negedge clk);
      exec_i = 1'b0;
      chk($sformatf("R8 vec %0d valid_q", i), W'(valid_q_o), W'(v[0]));
      chk($sformatf("R8 vec %0d chain", i), W'(chain_o), W'(v[0]));
      chk($sformatf("R1 vec %0d buf_q", i), buf_q_o, W'(32'h1000_0000 + i * 32'h0101));
    end

    // load a valid word, then check reserved opcode and idle cycles leave state alone
    @(negedge clk);
    exec_i = 1'b1; op_i = 2'd0; dest_i = 3'd7; word_i = 32'hCAFE_0001;
    @(negedge clk);
    op_i = 2'd3; dest_i = 3'd6; word_i = 32'hDEAD_BEEF; #1;
    chk("R9 reserved op we", W'(buf_we_o), 0);
    @(negedge clk);
    exec_i = 1'b0; op_i = 2'd0; dest_i = 3'd0;
    chk("R9 reserved op buffer", buf_q_o, 32'hCAFE_0001);
    chk("R9 reserved op valid", W'(valid_q_o), 1);
    chk("R9 reserved op chain", W'(chain_o), 1);
    #1;
    chk("R9 idle we", W'(buf_we_o), 0);
    repeat (2) @(negedge clk);
    chk("R9 idle valid", W'(valid_q_o), 1);
    chk("R8 idle chain", W'(chain_o), 1);

    // flow-controlled chain: refused port, then accepted on retry
    exec_i = 1'b1; op_i = 2'd2; dest_i = 3'd2; port_accept_i = 4'b1011;
    @(negedge clk);
    chk("R5 refused keeps word", W'(valid_q_o), 1);
    port_accept_i = 4'b0100;
    @(negedge clk);
    exec_i = 1'b0;
    chk("R5 accepted retry clears", W'(valid_q_o), 0);
    chk("R8 chain after accept", W'(chain_o), 0);

    // reset after a valid word
    exec_i = 1'b1; op_i = 2'd1; dest_i = 3'd7; word_i = 32'h0000_5A5A;
    @(negedge clk);
    exec_i = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears valid", W'(valid_q_o), 0);
    chk("R10 reset clears chain", W'(chain_o), 0);
    chk("R10 reset clears buffer", buf_q_o, 0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule